// File: doc/BRIEF.md
# Spine-Head Node Fetch with Write Forwarding

This unit sits after template instantiation in a graph-reduction engine. Each time an instantiation step presents the head atom of a new spine, the unit decides whether the reducer needs a heap node for unwinding. If an argument reference appears in the head, it is first replaced by the argument it names. The head is then classified. Integers, constructors and function references need nothing further. A heap pointer must be dereferenced.

The unit keeps a copy of every application written to the heap in the current instantiation cycle. There is one entry per allocation port, and each entry is tagged with its address. In the next cycle the pointer head is compared against all entries at once. On a match, the node is handed to the unwinder with no heap traffic. This covers a template whose head points at an application that the same template is allocating. On a mismatch, the unit raises a one-cycle stall, uses heap read port 0 during that bubble, and forwards the returned word. Because the bubble is only taken on a miss, templates can always use every allocation port.

Top module: `spine_head_fetch`

## Requirements
- R1: Head kinds are encoded on 3 bits as 0 integer, 1 constructor, 2 function, 3 pointer, 4 argument. A head that resolves to any kind other than pointer (3) raises no stall, issues no heap read and produces no node pulse.
- R2: For an argument head (kind 4), the low log2(NARGS) bits of `head_val` select slot i. That slot's kind is `arg_kinds[3*i +: 3]` and its value is `arg_vals[AW*i +: AW]`. Classification and addressing then use the substituted atom.
- R3: At every clock edge that is not stalled, forwarding entry i is reloaded from allocation port i. The entry is valid only if `alloc_we[i]` was high, so a cycle with no allocation leaves no valid entry.
- R4: Suppose a pointer head accepted at edge k matches a valid forwarding entry. Then no stall and no read occur. After edge k+1, `node_valid` is high for one cycle with that entry's data and `node_fwd` = 1.
- R5: Suppose a pointer head accepted at edge k matches no entry. Then for exactly the cycle between edges k and k+1, `stall` and `heap_rd_en` are high and `heap_rd_addr` equals the head address.
- R6: After such a miss, `heap_rd_data` is sampled at edge k+2 (one-cycle read latency). It appears on `node_data` with `node_valid` = 1 and `node_fwd` = 0 for the cycle after edge k+2.
- R7: While `stall` is high, `inst_valid`, the head inputs and the allocation ports are ignored.
- R8: If several valid entries carry the head address, the entry with the lowest port number supplies the data.
- R9: `node_valid` pulses exactly once per accepted pointer head and never otherwise.
- R10: A synchronous active-high `rst` clears all state, so `stall`, `heap_rd_en` and `node_valid` are low after the reset edge.
- R11: All MAXAPS allocation ports may write in the same cycle as a pointer head. A head naming any of those addresses is served by forwarding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inst_valid | input | 1 | A spine head is presented this cycle |
| head_kind | input | 3 | Kind of the head atom |
| head_val | input | AW | Head payload (address, or argument slot) |
| arg_kinds | input | 3*NARGS | Kinds of the frozen argument atoms |
| arg_vals | input | AW*NARGS | Values of the frozen argument atoms |
| alloc_we | input | MAXAPS | Heap write strobe per allocation port |
| alloc_addr | input | AW*MAXAPS | Heap write address per port |
| alloc_data | input | DW*MAXAPS | Heap write data per port |
| stall | output | 1 | Hold the instantiation stage (miss bubble) |
| heap_rd_en | output | 1 | Read request on heap port 0 |
| heap_rd_addr | output | AW | Read address on heap port 0 |
| heap_rd_data | input | DW | Read data, one cycle after the request |
| node_valid | output | 1 | Head node delivered to the unwinder |
| node_data | output | DW | Head node contents |
| node_fwd | output | 1 | Node came from the forwarding entries |

## Verification
Four timing rules are checked on every cycle by assertions. A stall never lasts two cycles. Every stall is followed, two cycles later, by a heap-sourced node. Every forwarded match yields a forwarded node on the next cycle. The forwarding entries stay frozen through a bubble. The bench scenarios are needed for what depends on data values. That covers argument substitution, the kind encoding, which port wins when addresses repeat, entries clearing after an idle cycle, and inputs presented during a bubble being discarded.

// File: rtl/spf_pkg.sv
package spf_pkg;
  localparam int KW = 3;
  typedef enum logic [KW-1:0] {
    K_INT = 3'd0,
    K_CON = 3'd1,
    K_FUN = 3'd2,
    K_VAR = 3'd3,
    K_ARG = 3'd4
  } atom_kind_e;
endpackage

// File: rtl/spf_head_resolve.sv
module spf_head_resolve
  import spf_pkg::*;
#(
  parameter int AW    = 10,
  parameter int NARGS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                take,
  input  logic [KW-1:0]       head_kind,
  input  logic [AW-1:0]       head_val,
  input  logic [KW*NARGS-1:0] arg_kinds,
  input  logic [AW*NARGS-1:0] arg_vals,
  output logic                head_v,
  output logic [AW-1:0]       head_addr
);
  localparam int IW = (NARGS > 1) ? $clog2(NARGS) : 1;

  logic [KW-1:0] r_kind;
  logic [AW-1:0] r_val;
  logic [IW-1:0] sel;

  assign sel = head_val[IW-1:0];

  // argument substitution happens before classification (R2)
  always_comb begin
    r_kind = head_kind;
    r_val  = head_val;
    if (head_kind == K_ARG) begin
      for (int i = 0; i < NARGS; i++) begin
        if (sel == IW'(i)) begin
          r_kind = arg_kinds[KW*i +: KW];
          r_val  = arg_vals[AW*i +: AW];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_v    <= 1'b0;
      head_addr <= '0;
    end else begin
      head_v    <= take && (r_kind == K_VAR);
      head_addr <= r_val;
    end
  end
endmodule

// File: rtl/spf_fwd_file.sv
module spf_fwd_file #(
  parameter int AW = 10,
  parameter int DW = 32,
  parameter int N  = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [N-1:0]  we,
  input  logic [AW*N-1:0] addr,
  input  logic [DW*N-1:0] data,
  input  logic [AW-1:0] lookup_addr,
  output logic          hit,
  output logic [DW-1:0] hit_data
);
  logic [N-1:0]  ent_v;
  logic [AW-1:0] ent_a [N];
  logic [DW-1:0] ent_d [N];
  logic [N-1:0]  match;

  for (genvar i = 0; i < N; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        ent_v[i] <= 1'b0;
        ent_a[i] <= '0;
        ent_d[i] <= '0;
      end else if (load) begin
        ent_v[i] <= we[i];
        ent_a[i] <= addr[AW*i +: AW];
        ent_d[i] <= data[DW*i +: DW];
      end
    end
    assign match[i] = ent_v[i] && (ent_a[i] == lookup_addr);
  end

  // lowest port number wins (R8)
  always_comb begin
    hit_data = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) hit_data = ent_d[i];
    end
  end
  assign hit = |match;

  // R7: entries frozen while the stage is held
  a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(ent_v));
endmodule

// File: rtl/spf_fetch_ctrl.sv
module spf_fetch_ctrl #(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          head_v,
  input  logic [AW-1:0] head_addr,
  input  logic          hit,
  input  logic [DW-1:0] hit_data,
  input  logic [DW-1:0] heap_rd_data,
  output logic          stall,
  output logic          heap_rd_en,
  output logic [AW-1:0] heap_rd_addr,
  output logic          node_valid,
  output logic [DW-1:0] node_data,
  output logic          node_fwd
);
  logic miss;
  logic pend;

  assign miss         = head_v && !hit;
  assign stall        = miss;
  assign heap_rd_en   = miss;
  assign heap_rd_addr = head_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend       <= 1'b0;
      node_valid <= 1'b0;
      node_data  <= '0;
      node_fwd   <= 1'b0;
    end else begin
      pend       <= miss;
      node_valid <= (head_v && hit) || pend;
      node_fwd   <= head_v && hit;
      if (head_v && hit) node_data <= hit_data;
      else if (pend)     node_data <= heap_rd_data;
    end
  end

  a_r5_single_bubble: assert property (@(posedge clk) disable iff (rst)
    stall |=> !stall);

  a_r6_miss_delivers: assert property (@(posedge clk) disable iff (rst)
    stall |=> ##1 (node_valid && !node_fwd));

  a_r4_hit_delivers: assert property (@(posedge clk) disable iff (rst)
    (head_v && hit) |=> (node_valid && node_fwd));
endmodule

// File: rtl/spine_head_fetch.sv
module spine_head_fetch
  import spf_pkg::*;
#(
  parameter int AW     = 10,
  parameter int DW     = 32,
  parameter int MAXAPS = 4,
  parameter int NARGS  = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  inst_valid,
  input  logic [2:0]            head_kind,
  input  logic [AW-1:0]         head_val,
  input  logic [3*NARGS-1:0]    arg_kinds,
  input  logic [AW*NARGS-1:0]   arg_vals,
  input  logic [MAXAPS-1:0]     alloc_we,
  input  logic [AW*MAXAPS-1:0]  alloc_addr,
  input  logic [DW*MAXAPS-1:0]  alloc_data,
  output logic                  stall,
  output logic                  heap_rd_en,
  output logic [AW-1:0]         heap_rd_addr,
  input  logic [DW-1:0]         heap_rd_data,
  output logic                  node_valid,
  output logic [DW-1:0]         node_data,
  output logic                  node_fwd
);
  logic          take;
  logic          load;
  logic          head_v;
  logic [AW-1:0] head_addr;
  logic          hit;
  logic [DW-1:0] hit_data;

  assign take = inst_valid && !stall;
  assign load = !stall;

  spf_head_resolve #(.AW(AW), .NARGS(NARGS)) u_resolve (
    .clk(clk), .rst(rst), .take(take),
    .head_kind(head_kind), .head_val(head_val),
    .arg_kinds(arg_kinds), .arg_vals(arg_vals),
    .head_v(head_v), .head_addr(head_addr)
  );

  spf_fwd_file #(.AW(AW), .DW(DW), .N(MAXAPS)) u_fwd (
    .clk(clk), .rst(rst), .load(load),
    .we(alloc_we), .addr(alloc_addr), .data(alloc_data),
    .lookup_addr(head_addr), .hit(hit), .hit_data(hit_data)
  );

  spf_fetch_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk(clk), .rst(rst), .head_v(head_v), .head_addr(head_addr),
    .hit(hit), .hit_data(hit_data), .heap_rd_data(heap_rd_data),
    .stall(stall), .heap_rd_en(heap_rd_en), .heap_rd_addr(heap_rd_addr),
    .node_valid(node_valid), .node_data(node_data), .node_fwd(node_fwd)
  );
endmodule

// File: tb/spine_head_fetch_bench.sv
module spine_head_fetch_bench;
  localparam int AW = 10, DW = 32, N = 4, NA = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic inst_valid = 1'b0;
  logic [2:0] head_kind = '0;
  logic [AW-1:0] head_val = '0;
  logic [3*NA-1:0] arg_kinds = '0;
  logic [AW*NA-1:0] arg_vals = '0;
  logic [N-1:0] alloc_we = '0;
  logic [AW*N-1:0] alloc_addr = '0;
  logic [DW*N-1:0] alloc_data = '0;
  logic [DW-1:0] heap_rd_data = '0;
  logic stall, heap_rd_en, node_valid, node_fwd;
  logic [AW-1:0] heap_rd_addr;
  logic [DW-1:0] node_data;

  spine_head_fetch u_spine_head_fetch (
    .clk(clk), .rst(rst), .inst_valid(inst_valid), .head_kind(head_kind),
    .head_val(head_val), .arg_kinds(arg_kinds), .arg_vals(arg_vals),
    .alloc_we(alloc_we), .alloc_addr(alloc_addr), .alloc_data(alloc_data),
    .stall(stall), .heap_rd_en(heap_rd_en), .heap_rd_addr(heap_rd_addr),
    .heap_rd_data(heap_rd_data), .node_valid(node_valid),
    .node_data(node_data), .node_fwd(node_fwd)
  );

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  string ctx = "";

  // reference model state
  logic m_hv = 0, m_pend = 0;
  logic [AW-1:0] m_ha = '0, m_pa = '0;
  logic m_fv [N];
  logic [AW-1:0] m_fa [N];
  logic [DW-1:0] m_fd [N];
  logic e_nv = 0, e_nf = 0;
  logic [DW-1:0] e_nd = '0;

  function automatic logic [DW-1:0] heapf(input logic [AW-1:0] a);
    return 32'hC0DE0000 ^ (32'(a) * 32'd2654435761);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s [%s] %s: actual=%0h expected=%0h", req, ctx, what, act, exp);
    end
  endtask

  task automatic cycle();
    logic hit, es, n_nv, n_nf, st_en;
    logic [DW-1:0] hd, n_nd;
    logic [AW-1:0] st_a, rv;
    logic [2:0] rk;
    hit = 0; hd = '0;
    for (int i = N - 1; i >= 0; i--)
      if (m_fv[i] && m_fa[i] == m_ha) begin hit = 1; hd = m_fd[i]; end
    es = m_hv && !hit;
    chk(stall === es, "R5", "stall", 32'(stall), 32'(es));
    chk(heap_rd_en === es, "R5", "heap_rd_en", 32'(heap_rd_en), 32'(es));
    if (es) chk(heap_rd_addr === m_ha, "R5", "heap_rd_addr", 32'(heap_rd_addr), 32'(m_ha));
    chk(node_valid === e_nv, "R9", "node_valid", 32'(node_valid), 32'(e_nv));
    if (e_nv) begin
      chk(node_data === e_nd, e_nf ? "R4" : "R6", "node_data", node_data, e_nd);
      chk(node_fwd === e_nf, e_nf ? "R4" : "R6", "node_fwd", 32'(node_fwd), 32'(e_nf));
    end
    n_nv = (m_hv && hit) || m_pend;
    n_nf = m_hv && hit;
    n_nd = (m_hv && hit) ? hd : heapf(m_pa);
    m_pend = es; m_pa = m_ha;
    if (!es) begin
      rk = head_kind; rv = head_val;
      if (head_kind == 3'd4) begin
        rk = arg_kinds[3*head_val[1:0] +: 3];
        rv = arg_vals[AW*head_val[1:0] +: AW];
      end
      m_hv = inst_valid && rk == 3'd3;
      m_ha = rv;
      for (int i = 0; i < N; i++) begin
        m_fv[i] = alloc_we[i];
        m_fa[i] = alloc_addr[AW*i +: AW];
        m_fd[i] = alloc_data[DW*i +: DW];
      end
    end else m_hv = 0;
    e_nv = n_nv; e_nf = n_nf; e_nd = n_nd;
    st_en = heap_rd_en; st_a = heap_rd_addr;
    @(posedge clk);
    @(negedge clk);
    heap_rd_data = st_en ? heapf(st_a) : '0;
  endtask

  task automatic idle();
    inst_valid = 0; alloc_we = '0;
  endtask

  task automatic head(input logic [2:0] k, input logic [AW-1:0] v);
    inst_valid = 1; head_kind = k; head_val = v;
  endtask

  task automatic alloc(input int p, input logic [AW-1:0] a, input logic [DW-1:0] d);
    alloc_we[p] = 1'b1;
    alloc_addr[AW*p +: AW] = a;
    alloc_data[DW*p +: DW] = d;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < N; i++) begin m_fv[i] = 0; m_fa[i] = '0; m_fd[i] = '0; end
    repeat (2) @(posedge clk);
    @(negedge clk);
    ctx = "R10 reset";
    chk(!stall && !heap_rd_en && !node_valid, "R10", "outputs in reset",
        {29'd0, stall, heap_rd_en, node_valid}, 32'd0);
    rst = 0;
    idle(); cycle();

    ctx = "R1 non-pointer heads";
    for (int k = 0; k < 3; k++) begin head(3'(k), 10'd5); alloc(0, 10'd5, 32'h11); cycle(); end
    idle(); cycle(); cycle();

    ctx = "R4 R11 same-template hit";
    head(3'd3, 10'd40);
    alloc(0, 10'd10, 32'hA0); alloc(1, 10'd20, 32'hA1);
    alloc(2, 10'd30, 32'hA2); alloc(3, 10'd40, 32'hA3);
    cycle(); idle(); cycle(); cycle();

    ctx = "R5 R6 miss";
    head(3'd3, 10'd77); cycle(); idle(); cycle(); cycle(); cycle();

    ctx = "R7 inputs during bubble";
    head(3'd3, 10'd99); cycle();
    head(3'd3, 10'd15); alloc(0, 10'd15, 32'hBEEF); cycle();
    idle(); cycle(); cycle(); cycle();

    ctx = "R2 argument head";
    arg_kinds = {3'd3, 3'd2, 3'd3, 3'd0};
    arg_vals = {10'd200, 10'd9, 10'd123, 10'd3};
    head(3'd4, 10'd1); alloc(2, 10'd123, 32'hCAFE); cycle(); idle(); cycle(); cycle();
    head(3'd4, 10'd2); cycle(); idle(); cycle(); cycle();
    head(3'd4, 10'd7); cycle(); idle(); cycle(); cycle(); cycle();

    ctx = "R8 duplicate addresses";
    head(3'd3, 10'd60); alloc(3, 10'd60, 32'h33); alloc(2, 10'd60, 32'h22);
    alloc(1, 10'd61, 32'h11); cycle(); idle(); cycle(); cycle();

    ctx = "R3 entries cleared by idle cycle";
    alloc(0, 10'd50, 32'h50); cycle(); idle();
    head(3'd3, 10'd50); cycle(); idle(); cycle(); cycle(); cycle();

    ctx = "random";
    for (int n = 0; n < 3000; n++) begin
      idle();
      if ($urandom_range(0, 3) != 0) begin
        head(3'($urandom_range(0, 4)), 10'($urandom_range(0, 15)));
      end
      arg_kinds = 12'($urandom);
      arg_vals = {10'($urandom_range(0, 15)), 10'($urandom_range(0, 15)),
                  10'($urandom_range(0, 15)), 10'($urandom_range(0, 15))};
      for (int p = 0; p < N; p++)
        if ($urandom_range(0, 1) == 1) alloc(p, 10'($urandom_range(0, 15)), $urandom);
      cycle();
    end
    idle(); cycle(); cycle(); cycle();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule